// File: doc/BRIEF.md
# Floating-Point Compare Flag Unit

This block takes one scalar floating-point compare instruction word and two operand buses, and returns a 4-bit NZCV condition-flag value. The compare runs in single or double precision. Single precision takes its operands from the low 32 bits of each bus. The instruction word selects the precision, chooses between a quiet and a signaling treatment of NaNs, and can replace the second operand with positive zero. When the word uses a reserved encoding, the block writes no flags and raises an error pulse instead.

Results are registered. An instruction presented with `insn_vld` high on one clock edge produces its outputs during the following cycle. A small state machine drives the outputs and has three states:
- `ST_IDLE`: no result.
- `ST_WRITE`: a flag-write pulse.
- `ST_REJECT`: an unallocated-encoding pulse.

It has three transitions, taken from any state:
- Valid and allocated goes to `ST_WRITE`.
- Valid and unallocated goes to `ST_REJECT`.
- No valid goes to `ST_IDLE`.

A new instruction may be presented on every cycle.

Top module: `fpcmp_flag_unit`

## Requirements
- R1: Equal operands give nzcv = 4'b0110.
- R2: First operand less than second gives nzcv = 4'b1000.
- R3: First operand greater than second gives nzcv = 4'b0010.
- R4: If either operand is a NaN (exponent all ones, fraction nonzero), the result is unordered and gives nzcv = 4'b0011.
- R5: Instruction bits [23:22] select the precision: 0 selects single precision (low 32 bits of each bus; upper bits have no effect), and 1 selects double precision (all 64 bits).
- R6: When instruction bit 3 is set, the second operand becomes +0.0 and the `opb` bus has no effect.
- R7: When instruction bit 4 is set (signaling form), `inv_exc` is raised for any NaN operand.
- R8: When instruction bit 4 is clear (quiet form), `inv_exc` is raised only for a signaling NaN, which is a NaN whose top fraction bit is clear.
- R9: The encoding is unallocated if any of the following holds: bits [31:29] are nonzero, bits [15:14] are nonzero, bits [2:0] are nonzero, or bits [23:22] are above 1. An unallocated instruction pulses `undef_err`, does not pulse `flag_we`, and leaves `nzcv` unchanged.
- R10: +0.0 and -0.0 compare equal.
- R11: When both operands are negative, the ordering is the inverse of the magnitude ordering. Denormals are compared exactly, with no flush to zero.
- R12: Each instruction presented with `insn_vld` produces exactly one `flag_we` or `undef_err` pulse in the cycle after the edge that accepted it. `nzcv` holds its value between writes, and `inv_exc` is only high together with `flag_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| insn_vld | input | 1 | Instruction word valid |
| insn | input | 32 | Compare instruction word |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| flag_we | output | 1 | Flag-write pulse |
| nzcv | output | 4 | Condition flags N,Z,C,V (bit 3 is N) |
| inv_exc | output | 1 | Invalid-operation exception, valid with flag_we |
| undef_err | output | 1 | Unallocated-encoding pulse |

## Verification
The failures that matter here show up at the ports one cycle after the instruction edge. A wrong state in the controller shows as one of three faults in that cycle: a missing pulse, a doubled pulse, or a flag write issued for a rejected word. A stale or wrongly loaded flag register shows as an nzcv value that does not match the relation, or as an nzcv that changes without a write. A vector table walks every relation in both precisions, with several cases inside it: sign-inverted magnitudes, denormals, signed zeros, and both NaN kinds. Directed cases then cover reset, each reserved field, garbage in the ignored operand bits, and back-to-back instructions.

// File: rtl/fpcmp_pkg.sv
package fpcmp_pkg;
    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_WRITE  = 2'd1,
        ST_REJECT = 2'd2
    } ctl_state_e;

    localparam int SP_EXP  = 8;
    localparam int SP_FRAC = 23;
    localparam int DP_EXP  = 11;
    localparam int DP_FRAC = 52;

    function automatic logic [3:0] rel_to_nzcv(rel_e r);
        unique case (r)
            REL_EQ:  return 4'b0110;
            REL_LT:  return 4'b1000;
            REL_GT:  return 4'b0010;
            default: return 4'b0011;
        endcase
    endfunction
endpackage

// File: rtl/fpcmp_decode.sv
module fpcmp_decode (
    input  logic [31:0] insn,
    output logic        illegal,
    output logic        use_dbl,
    output logic        zero_b,
    output logic        signaling
);
    logic unused_fields;
    assign unused_fields = ^{insn[28:24], insn[21:16], insn[13:5]};

    always_comb begin
        illegal   = (insn[31:29] != 3'b000) || (insn[15:14] != 2'b00) ||
                    (insn[2:0] != 3'b000)   || (insn[23:22] > 2'd1);
        use_dbl   = insn[22];
        zero_b    = insn[3];
        signaling = insn[4];
    end
endmodule

// File: rtl/fpcmp_core.sv
module fpcmp_core
    import fpcmp_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] a,
    input  logic [EXP_W+FRAC_W:0] b,
    output rel_e                  rel,
    output logic                  any_nan,
    output logic                  any_snan
);
    localparam int W = 1 + EXP_W + FRAC_W;

    logic nan_a, nan_b, snan_a, snan_b, both_zero, mag_lt, mag_gt;

    always_comb begin
        nan_a     = (&a[W-2:FRAC_W]) && (a[FRAC_W-1:0] != '0);
        nan_b     = (&b[W-2:FRAC_W]) && (b[FRAC_W-1:0] != '0);
        snan_a    = nan_a && !a[FRAC_W-1];
        snan_b    = nan_b && !b[FRAC_W-1];
        any_nan   = nan_a || nan_b;
        any_snan  = snan_a || snan_b;
        both_zero = (a[W-2:0] == '0) && (b[W-2:0] == '0);
        mag_lt    = a[W-2:0] < b[W-2:0];
        mag_gt    = a[W-2:0] > b[W-2:0];

        if (any_nan)
            rel = REL_UN;
        else if (both_zero || a == b)
            rel = REL_EQ;
        else if (a[W-1] != b[W-1])
            rel = a[W-1] ? REL_LT : REL_GT;
        else if (a[W-1])
            rel = mag_gt ? REL_LT : REL_GT;
        else
            rel = mag_lt ? REL_LT : REL_GT;
    end
endmodule

// File: rtl/fpcmp_flag_unit.sv
module fpcmp_flag_unit
    import fpcmp_pkg::*;
#(
    parameter int OP_W = 64
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_vld,
    input  logic [31:0]     insn,
    input  logic [OP_W-1:0] opa,
    input  logic [OP_W-1:0] opb,
    output logic            flag_we,
    output logic [3:0]      nzcv,
    output logic            inv_exc,
    output logic            undef_err
);
    localparam int SP_W = 1 + SP_EXP + SP_FRAC;
    localparam int DP_W = 1 + DP_EXP + DP_FRAC;

    logic illegal, use_dbl, zero_b, signaling;
    logic [OP_W-1:0] b_eff;
    rel_e rel_sp, rel_dp, rel_sel;
    logic nan_sp, nan_dp, snan_sp, snan_dp, inv_now;
    ctl_state_e state_q, state_d;
    logic [3:0] nzcv_q;
    logic       inv_q;

    fpcmp_decode u_dec (
        .insn(insn), .illegal(illegal), .use_dbl(use_dbl),
        .zero_b(zero_b), .signaling(signaling)
    );

    assign b_eff = zero_b ? '0 : opb;

    fpcmp_core #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_cmp_sp (
        .a(opa[SP_W-1:0]), .b(b_eff[SP_W-1:0]),
        .rel(rel_sp), .any_nan(nan_sp), .any_snan(snan_sp)
    );

    fpcmp_core #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_cmp_dp (
        .a(opa[DP_W-1:0]), .b(b_eff[DP_W-1:0]),
        .rel(rel_dp), .any_nan(nan_dp), .any_snan(snan_dp)
    );

    always_comb begin
        rel_sel = use_dbl ? rel_dp : rel_sp;
        if (signaling)
            inv_now = use_dbl ? nan_dp : nan_sp;
        else
            inv_now = use_dbl ? snan_dp : snan_sp;
    end

    always_comb begin
        if (!insn_vld)
            state_d = ST_IDLE;
        else if (illegal)
            state_d = ST_REJECT;
        else
            state_d = ST_WRITE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            nzcv_q  <= 4'b0000;
            inv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (insn_vld && !illegal) begin
                nzcv_q <= rel_to_nzcv(rel_sel);
                inv_q  <= inv_now;
            end
        end
    end

    always_comb begin
        flag_we   = 1'b0;
        undef_err = 1'b0;
        inv_exc   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_WRITE:  begin flag_we = 1'b1; inv_exc = inv_q; end
            ST_REJECT: undef_err = 1'b1;
            default:   ;
        endcase
    end
    assign nzcv = nzcv_q;

    // R12
    write_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> $past(insn_vld));
    // R12
    reject_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_err |-> $past(insn_vld));
    // R9
    reject_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_err |-> $stable(nzcv));
    // R12
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_we |-> $stable(nzcv));
    // R1
    legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (nzcv == 4'b0110 || nzcv == 4'b1000 ||
                     nzcv == 4'b0010 || nzcv == 4'b0011));
    // R4
    invalid_is_unordered_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_exc |-> (flag_we && nzcv == 4'b0011));
endmodule

// File: tb/fpcmp_flag_unit_tb.sv
`timescale 1ns/100ps
module fpcmp_flag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_vld = 1'b0;
    logic [31:0] insn = '0;
    logic [63:0] opa = '0, opb = '0;
    logic        flag_we, inv_exc, undef_err;
    logic [3:0]  nzcv;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fpcmp_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .insn_vld(insn_vld), .insn(insn),
        .opa(opa), .opb(opb), .flag_we(flag_we), .nzcv(nzcv),
        .inv_exc(inv_exc), .undef_err(undef_err)
    );

    // {type[1:0], opc[1:0], a, b, nzcv, inv}
    localparam int NV = 18;
    localparam logic [136:0] VECS [NV] = '{
        {2'd0, 2'd0, 64'h3F800000, 64'h3F800000, 4'b0110, 1'b0}, // R1
        {2'd0, 2'd0, 64'h3F800000, 64'h40000000, 4'b1000, 1'b0}, // R2
        {2'd0, 2'd0, 64'h40000000, 64'h3F800000, 4'b0010, 1'b0}, // R3
        {2'd0, 2'd0, 64'hBF800000, 64'hC0000000, 4'b0010, 1'b0}, // R11
        {2'd0, 2'd0, 64'hC0000000, 64'hBF800000, 4'b1000, 1'b0}, // R11
        {2'd0, 2'd0, 64'h7FC00000, 64'h3F800000, 4'b0011, 1'b0}, // R4 R8
        {2'd0, 2'd0, 64'h7F800001, 64'h3F800000, 4'b0011, 1'b1}, // R8
        {2'd0, 2'd2, 64'h7FC00000, 64'h3F800000, 4'b0011, 1'b1}, // R7
        {2'd0, 2'd0, 64'h00000000, 64'h80000000, 4'b0110, 1'b0}, // R10
        {2'd0, 2'd0, 64'h00000001, 64'h00000002, 4'b1000, 1'b0}, // R11
        {2'd0, 2'd1, 64'hBF800000, 64'h7FC00000, 4'b1000, 1'b0}, // R6
        {2'd1, 2'd0, 64'h3FF0000000000000, 64'h4000000000000000, 4'b1000, 1'b0}, // R5
        {2'd1, 2'd0, 64'hC008000000000000, 64'h3FF0000000000000, 4'b1000, 1'b0}, // R5
        {2'd1, 2'd2, 64'h7FF8000000000000, 64'h0, 4'b0011, 1'b1},               // R7
        {2'd0, 2'd0, 64'hDEADBEEF3F800000, 64'h123456783F800000, 4'b0110, 1'b0}, // R5
        {2'd1, 2'd0, 64'h7FF0000000000001, 64'h3FF0000000000000, 4'b0011, 1'b1}, // R8
        {2'd0, 2'd0, 64'h7F800000, 64'h40000000, 4'b0010, 1'b0},               // R3
        {2'd1, 2'd3, 64'h7FF8000000000000, 64'hFFF0000000000001, 4'b0011, 1'b1} // R6 R7
    };

    function automatic logic [31:0] mk(logic [1:0] typ, logic [1:0] opc);
        return {3'b000, 5'b11110, typ, 1'b1, 5'd3, 2'b00, 4'b1000, 5'd7, opc, 3'b000};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] w, logic [63:0] a, logic [63:0] b);
        insn_vld = 1'b1; insn = w; opa = a; opb = b;
        @(negedge clk);
        insn_vld = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 reset flag_we", {63'd0, flag_we}, 64'd0);
        chk("R12 reset undef_err", {63'd0, undef_err}, 64'd0);
        chk("R12 reset nzcv", {60'd0, nzcv}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk, back-to-back instructions
        for (int i = 0; i < NV; i++) begin
            insn_vld = 1'b1;
            insn = mk(VECS[i][136:135], VECS[i][134:133]);
            opa = VECS[i][132:69];
            opb = VECS[i][68:5];
            @(negedge clk);
            chk($sformatf("R12 vec%0d flag_we", i), {63'd0, flag_we}, 64'd1);
            chk($sformatf("R1-4 vec%0d nzcv", i), {60'd0, nzcv}, {60'd0, VECS[i][4:1]});
            chk($sformatf("R7/R8 vec%0d inv", i), {63'd0, inv_exc}, {63'd0, VECS[i][0]});
        end
        insn_vld = 1'b0;
        @(negedge clk);
        chk("R12 idle no write", {63'd0, flag_we}, 64'd0);
        chk("R12 idle nzcv held", {60'd0, nzcv}, 64'h3);

        // set known flags: greater
        issue(mk(2'd0, 2'd0), 64'h40000000, 64'h3F800000);
        chk("R3 setup", {60'd0, nzcv}, 64'h2);

        // unallocated encodings (R9)
        issue(mk(2'd2, 2'd0), 64'h3F800000, 64'h3F800000);
        chk("R9 type2 err", {63'd0, undef_err}, 64'd1);
        chk("R9 type2 no write", {63'd0, flag_we}, 64'd0);
        chk("R9 type2 nzcv kept", {60'd0, nzcv}, 64'h2);
        issue(mk(2'd0, 2'd0) | 32'h2000_0000, 64'h0, 64'h3F800000);
        chk("R9 top bits err", {63'd0, undef_err}, 64'd1);
        chk("R9 top bits nzcv kept", {60'd0, nzcv}, 64'h2);
        issue(mk(2'd0, 2'd0) | 32'h0000_4000, 64'h0, 64'h3F800000);
        chk("R9 op bits err", {63'd0, undef_err}, 64'd1);
        issue(mk(2'd0, 2'd0) | 32'h0000_0001, 64'h0, 64'h3F800000);
        chk("R9 low bits err", {63'd0, undef_err}, 64'd1);
        chk("R9 low bits no write", {63'd0, flag_we}, 64'd0);
        @(negedge clk);
        chk("R12 single err pulse", {63'd0, undef_err}, 64'd0);

        // zero-compare ignores opb, -0 vs +0
        issue(mk(2'd1, 2'd1), 64'h8000000000000000, 64'h7FF0000000000001);
        chk("R6 R10 zero cmp nzcv", {60'd0, nzcv}, 64'h6);
        chk("R6 zero cmp no inv", {63'd0, inv_exc}, 64'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule